// File: doc/BRIEF.md
# Prioritized Interrupt Level Encoder

This block gathers seven interrupt request lines and presents the most urgent pending one to a processor as a three-bit, active-low priority level. Each request line has a fixed level: the line at index k carries level k+1. Level 0 means that nothing is pending. A request is latched into a pending bit, so a short pulse on a request line is not lost before it is serviced. A separate output compares the encoded level against a supplied current-priority mask and says whether the processor would accept the interrupt.

When the processor runs an interrupt-acknowledge cycle, it places the level it is servicing on three address lines and drops its address strobe. The block looks up an eight-bit vector number for that level in a small register file that software can write. It drives the vector onto the low data byte and, one cycle later, asserts a data-transfer acknowledge. It also sends a one-clock acknowledge pulse to the matching source. That source's pending bit is cleared only if its request line has already been released. The vector and the acknowledge stay up until the address strobe returns high.

Top module: `irq_level_encoder`

## Requirements
- R1: After reset, `ipl_n_o` is 3'b111, `dtack_n_o` is high, and `vec_oe_o` and `src_ack_o` are low. Each level L (1..7) has the vector value 0x40+L.
- R2: A request line that is high at a rising clock edge sets its pending bit. The pending bit stays set after the line falls. `ipl_n_o` is the bitwise inverse of the highest pending level, where `req_i[k]` has level k+1, and it is 3'b111 when nothing is pending.
- R3: `take_o` is high exactly when the encoded level is strictly greater than `mask_i`. It is always low when no level is pending.
- R4: In idle, if `iack_i` is high and `as_n_i` is low at a clock edge, then after that edge `vec_oe_o` is high and `vec_o` holds the vector of level `addr_i`. With `iack_i` low, the block does not respond. The vector stays stable while it is driven.
- R5: An acknowledge with `addr_i` = 0 returns the spurious vector 0x18 and pulses no source.
- R6: In the cycle in which the vector is first driven, `src_ack_o` bit `addr_i`-1 is high for exactly one clock. At most one bit of `src_ack_o` is ever high.
- R7: `dtack_n_o` goes low one clock after `vec_oe_o` rises and stays low while `as_n_i` is low. At the first edge with `as_n_i` high, both `dtack_n_o` and `vec_oe_o` are released.
- R8: The acknowledge pulse clears the source's pending bit only if its request line is low at the edge that ends the pulse. Otherwise the bit stays set.
- R9: When `wr_en_i` is high at an edge with `wr_lvl_i` in 1..7, `wr_data_i` is written into that level's vector. A write with `wr_lvl_i` = 0 changes no vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_i | input | 7 | Interrupt requests, active high; index k is level k+1 |
| mask_i | input | 3 | Current processor priority mask |
| ipl_n_o | output | 3 | Encoded highest pending level, active low |
| take_o | output | 1 | Encoded level is above the mask |
| iack_i | input | 1 | Current bus cycle is an interrupt acknowledge |
| as_n_i | input | 1 | Address strobe, active low |
| addr_i | input | 3 | Level under acknowledge (address bits 3..1) |
| vec_o | output | 8 | Vector number for the low data byte |
| vec_oe_o | output | 1 | Vector drive enable |
| dtack_n_o | output | 1 | Data-transfer acknowledge, active low |
| src_ack_o | output | 7 | One-clock acknowledge pulse per source |
| wr_en_i | input | 1 | Vector register write enable |
| wr_lvl_i | input | 3 | Level whose vector is written |
| wr_data_i | input | 8 | Vector write data |

## Verification
The assertions check the acknowledge handshake on every cycle:
- the source acknowledge is one-hot and lasts a single clock;
- the data acknowledge is never low without the vector drive, and it appears only after the vector rises;
- once the strobe returns high, the acknowledge and the drive are released;
- the vector holds steady while it is driven;
- with no level pending, `take_o` stays low.

Only the bench scenarios can show the value-dependent behaviour:
- that the right level wins among several pending requests;
- that the mask comparison treats equal levels as ignored;
- that a vector written by software is the one returned, and that the level-0 path gives the spurious vector;
- that the pending bit clears only when its request line was released before the acknowledge.

// File: rtl/irq_enc_pkg.sv
`timescale 1ns/1ps
package irq_enc_pkg;
  localparam int NUM_SRC = 7;
  localparam int LVL_W   = $clog2(NUM_SRC + 1);
  localparam int VEC_W   = 8;

  typedef logic [LVL_W-1:0] lvl_t;
  typedef logic [VEC_W-1:0] vec_t;

  typedef enum logic [1:0] {
    ACK_IDLE  = 2'd0,
    ACK_SERVE = 2'd1,
    ACK_HOLD  = 2'd2
  } ack_state_e;
endpackage

// File: rtl/irq_rst_sync.sv
`timescale 1ns/1ps
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/irq_pending_enc.sv
`timescale 1ns/1ps
module irq_pending_enc
  import irq_enc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic [NUM_SRC-1:0] ack_i,
  output lvl_t               level_o
);
  logic [NUM_SRC-1:0] pend_q;
  logic [NUM_SRC-1:0] pend_d;

  // A held request re-sets its bit; an acknowledge only clears a released line.
  always_comb begin
    pend_d = req_i | (pend_q & ~ack_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  // Highest index wins: later iterations override earlier ones.
  always_comb begin
    level_o = '0;
    for (int k = 0; k < NUM_SRC; k++) begin
      if (pend_q[k]) level_o = lvl_t'(k + 1);
    end
  end
endmodule

// File: rtl/irq_vector_file.sv
`timescale 1ns/1ps
module irq_vector_file
  import irq_enc_pkg::*;
#(
  parameter int VEC_BASE = 'h40,
  parameter int SPUR_VEC = 'h18
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en_i,
  input  lvl_t wr_lvl_i,
  input  vec_t wr_data_i,
  input  lvl_t rd_lvl_i,
  output vec_t rd_vec_o
);
  vec_t vec_arr [NUM_SRC];

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_vec
    logic hit;
    vec_t vec_q;
    vec_t vec_d;

    assign hit = wr_en_i && (wr_lvl_i == lvl_t'(g + 1));

    always_comb begin
      vec_d = hit ? wr_data_i : vec_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vec_q <= vec_t'(VEC_BASE + g + 1);
      else        vec_q <= vec_d;
    end

    assign vec_arr[g] = vec_q;
  end

  // Level 0, or any level without a source, reads the spurious vector.
  always_comb begin
    rd_vec_o = vec_t'(SPUR_VEC);
    for (int k = 0; k < NUM_SRC; k++) begin
      if (rd_lvl_i == lvl_t'(k + 1)) rd_vec_o = vec_arr[k];
    end
  end
endmodule

// File: rtl/irq_ack_ctrl.sv
`timescale 1ns/1ps
module irq_ack_ctrl
  import irq_enc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               iack_i,
  input  logic               as_n_i,
  input  lvl_t               addr_i,
  input  vec_t               sel_vec_i,
  output vec_t               vec_o,
  output logic               vec_oe_o,
  output logic               dtack_n_o,
  output logic [NUM_SRC-1:0] src_ack_o
);
  ack_state_e         state_q, state_d;
  vec_t               vec_q;
  logic               vec_ld;
  logic               oe_q, oe_d;
  logic               dtk_n_q, dtk_n_d;
  logic [NUM_SRC-1:0] ack_q, ack_d;
  logic               start;

  assign start  = iack_i && !as_n_i;
  assign vec_ld = (state_q == ACK_IDLE) && start;

  always_comb begin
    state_d = state_q;
    oe_d    = oe_q;
    dtk_n_d = dtk_n_q;
    ack_d   = '0;
    case (state_q)
      ACK_IDLE: begin
        if (start) begin
          state_d = ACK_SERVE;
          oe_d    = 1'b1;
          for (int k = 0; k < NUM_SRC; k++) begin
            ack_d[k] = (addr_i == lvl_t'(k + 1));
          end
        end
      end
      ACK_SERVE: begin
        if (as_n_i) begin
          state_d = ACK_IDLE;
          oe_d    = 1'b0;
        end else begin
          state_d = ACK_HOLD;
          dtk_n_d = 1'b0;
        end
      end
      ACK_HOLD: begin
        if (as_n_i) begin
          state_d = ACK_IDLE;
          oe_d    = 1'b0;
          dtk_n_d = 1'b1;
        end
      end
      default: begin
        state_d = ACK_IDLE;
        oe_d    = 1'b0;
        dtk_n_d = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ACK_IDLE;
      oe_q    <= 1'b0;
      dtk_n_q <= 1'b1;
      ack_q   <= '0;
    end else begin
      state_q <= state_d;
      oe_q    <= oe_d;
      dtk_n_q <= dtk_n_d;
      ack_q   <= ack_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      vec_q <= '0;
    else if (vec_ld) vec_q <= sel_vec_i;
  end

  assign vec_o     = oe_q ? vec_q : '0;
  assign vec_oe_o  = oe_q;
  assign dtack_n_o = dtk_n_q;
  assign src_ack_o = ack_q;
endmodule

// File: rtl/irq_level_encoder.sv
`timescale 1ns/1ps
module irq_level_encoder
  import irq_enc_pkg::*;
#(
  parameter int VEC_BASE = 'h40,
  parameter int SPUR_VEC = 'h18
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic [LVL_W-1:0]   mask_i,
  output logic [LVL_W-1:0]   ipl_n_o,
  output logic               take_o,
  input  logic               iack_i,
  input  logic               as_n_i,
  input  logic [LVL_W-1:0]   addr_i,
  output logic [VEC_W-1:0]   vec_o,
  output logic               vec_oe_o,
  output logic               dtack_n_o,
  output logic [NUM_SRC-1:0] src_ack_o,
  input  logic               wr_en_i,
  input  logic [LVL_W-1:0]   wr_lvl_i,
  input  logic [VEC_W-1:0]   wr_data_i
);
  logic               rst_sync_n;
  lvl_t               level;
  vec_t               sel_vec;
  logic [NUM_SRC-1:0] ack_pulse;

  irq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  irq_pending_enc u_pend (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .req_i   (req_i),
    .ack_i   (ack_pulse),
    .level_o (level)
  );

  irq_vector_file #(
    .VEC_BASE (VEC_BASE),
    .SPUR_VEC (SPUR_VEC)
  ) u_vec (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en_i   (wr_en_i),
    .wr_lvl_i  (wr_lvl_i),
    .wr_data_i (wr_data_i),
    .rd_lvl_i  (addr_i),
    .rd_vec_o  (sel_vec)
  );

  irq_ack_ctrl u_ack (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .iack_i    (iack_i),
    .as_n_i    (as_n_i),
    .addr_i    (addr_i),
    .sel_vec_i (sel_vec),
    .vec_o     (vec_o),
    .vec_oe_o  (vec_oe_o),
    .dtack_n_o (dtack_n_o),
    .src_ack_o (ack_pulse)
  );

  assign src_ack_o = ack_pulse;
  assign ipl_n_o   = ~level;
  assign take_o    = (level > mask_i);
endmodule

// File: rtl/irq_level_encoder_chk.sv
`timescale 1ns/1ps
module irq_level_encoder_chk
  import irq_enc_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic [LVL_W-1:0]   ipl_n_o,
  input logic               take_o,
  input logic               as_n_i,
  input logic [VEC_W-1:0]   vec_o,
  input logic               vec_oe_o,
  input logic               dtack_n_o,
  input logic [NUM_SRC-1:0] src_ack_o
);
  // R3
  idle_no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ipl_n_o == '1) |-> !take_o);

  // R6
  ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(src_ack_o));

  // R6
  ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_ack_o) |=> (src_ack_o == '0));

  // R7
  dtack_needs_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dtack_n_o |-> vec_oe_o);

  // R7
  dtack_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vec_oe_o) |-> dtack_n_o);

  // R7
  dtack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dtack_n_o && as_n_i) |=> (dtack_n_o && !vec_oe_o));

  // R4
  vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_oe_o && $past(vec_oe_o)) |-> $stable(vec_o));
endmodule

bind irq_level_encoder irq_level_encoder_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ipl_n_o   (ipl_n_o),
  .take_o    (take_o),
  .as_n_i    (as_n_i),
  .vec_o     (vec_o),
  .vec_oe_o  (vec_oe_o),
  .dtack_n_o (dtack_n_o),
  .src_ack_o (src_ack_o)
);

// File: tb/irq_level_encoder_tb.sv
`timescale 1ns/1ps
module irq_level_encoder_tb;
  logic       clk;
  logic       rst_n;
  logic [6:0] req;
  logic [2:0] mask;
  logic [2:0] ipl_n;
  logic       take;
  logic       iack;
  logic       as_n;
  logic [2:0] addr;
  logic [7:0] vec;
  logic       vec_oe;
  logic       dtack_n;
  logic [6:0] src_ack;
  logic       wr_en;
  logic [2:0] wr_lvl;
  logic [7:0] wr_data;

  int n_tests;
  int n_fail;

  irq_level_encoder u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (req),
    .mask_i    (mask),
    .ipl_n_o   (ipl_n),
    .take_o    (take),
    .iack_i    (iack),
    .as_n_i    (as_n),
    .addr_i    (addr),
    .vec_o     (vec),
    .vec_oe_o  (vec_oe),
    .dtack_n_o (dtack_n),
    .src_ack_o (src_ack),
    .wr_en_i   (wr_en),
    .wr_lvl_i  (wr_lvl),
    .wr_data_i (wr_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct packed {
    logic [6:0] req;
    logic [2:0] mask;
    logic [2:0] ipl_n;
    logic       take;
  } row_t;

  // R2 / R3 patterns: requests held, mask, expected level (inverted), expected take
  localparam row_t TBL [10] = '{
    '{7'b0000000, 3'd0, 3'b111, 1'b0},
    '{7'b0000001, 3'd0, 3'b110, 1'b1},
    '{7'b0000001, 3'd1, 3'b110, 1'b0},
    '{7'b1000000, 3'd6, 3'b000, 1'b1},
    '{7'b1000000, 3'd7, 3'b000, 1'b0},
    '{7'b0010100, 3'd4, 3'b010, 1'b1},
    '{7'b0010100, 3'd5, 3'b010, 1'b0},
    '{7'b0001111, 3'd2, 3'b011, 1'b1},
    '{7'b0101010, 3'd0, 3'b001, 1'b1},
    '{7'b1111111, 3'd3, 3'b000, 1'b1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    req = '0; mask = '0; iack = 1'b0; as_n = 1'b1; addr = '0;
    wr_en = 1'b0; wr_lvl = '0; wr_data = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic start_ack(input logic [2:0] a);
    iack = 1'b1; as_n = 1'b0; addr = a;
    @(negedge clk);
  endtask

  task automatic end_ack();
    as_n = 1'b1; iack = 1'b0; addr = '0;
    @(negedge clk);
    chk("R7 dtack released", 32'(dtack_n), 32'd1);
    chk("R7 vec drive released", 32'(vec_oe), 32'd0);
  endtask

  task automatic write_vec(input logic [2:0] l, input logic [7:0] d);
    wr_en = 1'b1; wr_lvl = l; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    n_tests = 0;
    n_fail  = 0;
    do_reset();

    // R1 reset state
    chk("R1 ipl_n", 32'(ipl_n), 32'h7);
    chk("R1 dtack_n", 32'(dtack_n), 32'd1);
    chk("R1 vec_oe", 32'(vec_oe), 32'd0);
    chk("R1 src_ack", 32'(src_ack), 32'd0);

    // R2 R3 table
    for (int i = 0; i < 10; i++) begin
      do_reset();
      req  = TBL[i].req;
      mask = TBL[i].mask;
      @(negedge clk);
      chk("R2 level", 32'(ipl_n), 32'(TBL[i].ipl_n));
      chk("R3 take", 32'(take), 32'(TBL[i].take));
    end

    // R2 pulse latched, then R4 R6 R7 R8 acknowledge with released line
    do_reset();
    req = 7'b0010000;
    @(negedge clk);
    req = '0;
    @(negedge clk);
    chk("R2 sticky pending", 32'(ipl_n), 32'h2);
    start_ack(3'd5);
    chk("R4 vec_oe", 32'(vec_oe), 32'd1);
    chk("R1 default vector 5", 32'(vec), 32'h45);
    chk("R6 src_ack pulse", 32'(src_ack), 32'h10);
    chk("R7 dtack not yet", 32'(dtack_n), 32'd1);
    @(negedge clk);
    chk("R7 dtack asserted", 32'(dtack_n), 32'd0);
    chk("R6 pulse ends", 32'(src_ack), 32'd0);
    chk("R8 pending cleared", 32'(ipl_n), 32'h7);
    @(negedge clk);
    chk("R7 dtack held", 32'(dtack_n), 32'd0);
    chk("R4 vec held", 32'(vec), 32'h45);
    end_ack();

    // R8 held line keeps pending
    req = 7'b0000010;
    @(negedge clk);
    start_ack(3'd2);
    chk("R4 vector 2", 32'(vec), 32'h42);
    @(negedge clk);
    chk("R8 pending kept", 32'(ipl_n), 32'h5);
    end_ack();
    req = '0;
    @(negedge clk);
    chk("R8 still pending", 32'(ipl_n), 32'h5);
    start_ack(3'd2);
    @(negedge clk);
    chk("R8 cleared on second ack", 32'(ipl_n), 32'h7);
    end_ack();

    // R9 write
    write_vec(3'd6, 8'hA5);
    start_ack(3'd6);
    chk("R9 written vector", 32'(vec), 32'hA5);
    @(negedge clk);
    end_ack();

    // R5 R9 level-0 write and spurious ack
    write_vec(3'd0, 8'h77);
    start_ack(3'd0);
    chk("R5 spurious vector", 32'(vec), 32'h18);
    chk("R5 no src_ack", 32'(src_ack), 32'd0);
    @(negedge clk);
    end_ack();
    start_ack(3'd7);
    chk("R9 level7 untouched", 32'(vec), 32'h47);
    @(negedge clk);
    end_ack();

    // R4 no response without iack
    as_n = 1'b0; addr = 3'd3; iack = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R4 no drive without iack", 32'(vec_oe), 32'd0);
    chk("R4 no dtack without iack", 32'(dtack_n), 32'd1);
    as_n = 1'b1;
    @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #800000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule